// File: doc/BRIEF.md
# Digital Upconverter Phase Accumulator

This block is the bank of numerically controlled oscillators inside a digital upconverter. Each channel keeps a 32-bit phase accumulator. On every clock the accumulator advances by that channel's active frequency tuning word. The channel's output phase is the upper half of the accumulator plus a 16-bit phase offset. A sine/cosine lookup further down the chain consumes that phase word.

Software reaches the block through an 8-bit byte-write port. Tuning words and phase offsets are written byte by byte into staging registers, and those writes leave the running oscillators untouched. A single write to a shared strobe address then moves the staged values of every channel into the active registers on the same clock edge, so all channels retune together.

Each channel also has a config byte that holds three things:
- a level clear, which pins the accumulator at zero;
- a one-shot clear, which is latched and zeroes the accumulator at the next strobe only;
- a 6-bit select field, which is passed out to downstream logic.

Top module: `duc_nco`

## Requirements
- R1: After reset, every channel's phase output and select output are zero, and all staged and active words are zero.
- R2: Channel c's tuning word is staged by byte writes at address 16*c+4 (bits 31:24) through 16*c+7 (bits 7:0). Staged bytes do not change any output until a strobe.
- R3: Channel c's phase offset is staged at address 16*c+8 (bits 15:8) and 16*c+9 (bits 7:0). It takes effect only after a strobe.
- R4: A write of any data to the strobe address 16*NCH copies every channel's staged tuning word and offset into its active registers. The accumulator step taken on that same edge still uses the old tuning word; the new word is used from the next edge on.
- R5: Unless it is cleared, each accumulator adds its active tuning word on every clock, wrapping modulo 2^32.
- R6: The config byte sits at address 16*c+0. While bit 0 (level clear) is 1, the accumulator is loaded with zero on every clock.
- R7: Writing the config byte with bit 1 set latches a one-shot clear request. A later config write with bit 1 at 0 does not cancel it. At the next strobe the accumulator is loaded with zero and the request drops, so later strobes do not clear.
- R8: The phase output of a channel equals accumulator bits 31:16 plus the active phase offset, modulo 2^16.
- R9: Config bits 7:2 appear on that channel's 6-bit select output from the clock after the write.
- R10: Writes to unused offsets in a channel block, and to addresses above the strobe, change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | AW (8) | Byte write address |
| wr_data | input | 8 | Byte write data |
| phase_out | output | NCH*16 | Per-channel output phase, channel 0 in the low bits |
| sel_out | output | NCH*6 | Per-channel select field, channel 0 in the low bits |

## Verification
The bench aims at these corner cases, and each one exposes a specific mistake:
- **Staged bytes ahead of a strobe.** A design that lets staged bytes leak into the active registers would change the phase rate before the strobe.
- **The strobe edge itself.** A design that uses the new tuning word on the strobe edge would be off by one step ever after.
- **Accumulator wrap.** A tuning word near 2^32 forces the accumulator to wrap; a missing wrap would show up in the output phase.
- **Offset wrap.** A large phase offset makes the output adder overflow past 2^16.
- **One-shot clear.** The request is written, a config write with bit 1 at 0 follows, then several strobes. A design that cancelled the request, cleared at once, or kept clearing on later strobes would show a phase jump in the wrong cycle.
- **Unused addresses.** Writes to unused offsets check that the address decode is complete.

// File: rtl/duc_nco.sv
module duc_nco #(
  parameter int NCH   = 2,
  parameter int FTW_W = 32,
  parameter int PH_W  = 16,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  output logic [NCH*PH_W-1:0] phase_out,
  output logic [NCH*6-1:0]    sel_out
);
  localparam int FB       = FTW_W / 8;
  localparam int PB       = PH_W / 8;
  localparam int CFG_OFS  = 0;
  localparam int FTW_OFS  = 4;
  localparam int POF_OFS  = 8;
  localparam int STB_ADDR = NCH * 16;

  logic            stb;
  logic [AW-5:0]   a_ch;
  logic [3:0]      a_off;
  logic [NCH-1:0]  clr_v, pend_v;
  logic [NCH*FTW_W-1:0] acc_v, ftwa_v;

  assign stb   = wr_en && (wr_addr == AW'(STB_ADDR));
  assign a_ch  = wr_addr[AW-1:4];
  assign a_off = wr_addr[3:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic             hit;
    logic [FTW_W-1:0] ftw_s, ftw_a, acc;
    logic [PH_W-1:0]  pof_s, pof_a;
    logic             clr_q, pend;
    logic [5:0]       sel_q;

    assign hit = wr_en && (a_ch == (AW-4)'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ftw_s <= '0; ftw_a <= '0; acc <= '0;
        pof_s <= '0; pof_a <= '0;
        clr_q <= 1'b0; pend <= 1'b0; sel_q <= '0;
      end else begin
        if (hit && a_off == 4'(CFG_OFS)) begin
          clr_q <= wr_data[0];
          sel_q <= wr_data[7:2];
        end
        if (stb)
          pend <= 1'b0;
        else if (hit && a_off == 4'(CFG_OFS) && wr_data[1])
          pend <= 1'b1;
        for (int k = 0; k < FB; k++)
          if (hit && a_off == 4'(FTW_OFS + k))
            ftw_s[8*(FB-1-k) +: 8] <= wr_data;
        for (int k = 0; k < PB; k++)
          if (hit && a_off == 4'(POF_OFS + k))
            pof_s[8*(PB-1-k) +: 8] <= wr_data;
        if (stb) begin
          ftw_a <= ftw_s;
          pof_a <= pof_s;
        end
        if (clr_q || (stb && pend))
          acc <= '0;
        else
          acc <= acc + ftw_a;
      end
    end

    assign phase_out[c*PH_W +: PH_W] = acc[FTW_W-1 -: PH_W] + pof_a;
    assign sel_out[c*6 +: 6]         = sel_q;
    assign clr_v[c]                  = clr_q;
    assign pend_v[c]                 = pend;
    assign acc_v[c*FTW_W +: FTW_W]   = acc;
    assign ftwa_v[c*FTW_W +: FTW_W]  = ftw_a;
  end
endmodule

// File: rtl/duc_nco_chk.sv
module duc_nco_chk #(
  parameter int NCH   = 2,
  parameter int FTW_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stb,
  input logic [NCH-1:0]       clr_v,
  input logic [NCH-1:0]       pend_v,
  input logic [NCH*FTW_W-1:0] acc_v,
  input logic [NCH*FTW_W-1:0] ftwa_v
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6
    clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v[c] |=> acc_v[c*FTW_W +: FTW_W] == '0);
    // R5
    accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !clr_v[c]) |=> acc_v[c*FTW_W +: FTW_W] ==
        FTW_W'($past(acc_v[c*FTW_W +: FTW_W]) + $past(ftwa_v[c*FTW_W +: FTW_W])));
    // R2
    ftw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(ftwa_v[c*FTW_W +: FTW_W]));
    // R7
    once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && pend_v[c]) |=> (!pend_v[c] && acc_v[c*FTW_W +: FTW_W] == '0));
  end
endmodule

bind duc_nco duc_nco_chk #(.NCH(NCH), .FTW_W(FTW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb), .clr_v(clr_v), .pend_v(pend_v),
  .acc_v(acc_v), .ftwa_v(ftwa_v)
);

// File: tb/duc_nco_bench.sv
`timescale 1ns/1ps
module duc_nco_bench;
  localparam int NCH = 2;
  localparam int STB = NCH * 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [NCH*16-1:0] phase_out;
  logic [NCH*6-1:0]  sel_out;

  always #2 clk = ~clk;

  duc_nco u_duc_nco (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .phase_out, .sel_out);

  logic [31:0] m_acc [NCH], m_fs [NCH], m_fa [NCH];
  logic [15:0] m_ps [NCH], m_pa [NCH];
  logic [5:0]  m_sel [NCH];
  bit          m_clr [NCH], m_pend [NCH];
  int vectors = 0, errors = 0;
  string cur_req = "R1";

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_acc[c] = 0; m_fs[c] = 0; m_fa[c] = 0; m_ps[c] = 0; m_pa[c] = 0;
      m_sel[c] = 0; m_clr[c] = 0; m_pend[c] = 0;
    end
  endtask

  task automatic model_edge(bit we, logic [7:0] a, logic [7:0] d);
    bit s = we && a == 8'(STB);
    for (int c = 0; c < NCH; c++) begin
      if (m_clr[c] || (s && m_pend[c])) m_acc[c] = 0;
      else m_acc[c] = m_acc[c] + m_fa[c];
      if (s) begin m_fa[c] = m_fs[c]; m_pa[c] = m_ps[c]; m_pend[c] = 0; end
    end
    if (we && a < 8'(STB)) begin
      int c = int'(a) / 16;
      int o = int'(a) % 16;
      if (o == 0) begin m_clr[c] = d[0]; m_sel[c] = d[7:2]; if (d[1]) m_pend[c] = 1; end
      else if (o >= 4 && o <= 7) m_fs[c][8*(7-o) +: 8] = d;
      else if (o == 8) m_ps[c][15:8] = d;
      else if (o == 9) m_ps[c][7:0] = d;
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] ep = m_acc[c][31:16] + m_pa[c];
      vectors++;
      if (phase_out[c*16 +: 16] !== ep || sel_out[c*6 +: 6] !== m_sel[c]) begin
        errors++;
        $display("FAIL %s ch%0d phase=%h sel=%h expected phase=%h sel=%h",
                 cur_req, c, phase_out[c*16 +: 16], sel_out[c*6 +: 6], ep, m_sel[c]);
      end
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    wr_en = 0;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic put_ftw(int c, logic [31:0] w);
    for (int k = 0; k < 4; k++) cyc(1, 8'(16*c + 4 + k), w[8*(3-k) +: 8]);
  endtask

  task automatic put_pof(int c, logic [15:0] p);
    cyc(1, 8'(16*c + 8), p[15:8]);
    cyc(1, 8'(16*c + 9), p[7:0]);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare();
    rst_n = 1; idle(2);
    cur_req = "R2"; put_ftw(0, 32'h0001_0000); put_ftw(1, 32'h1234_5678); idle(4);
    cur_req = "R3"; put_pof(1, 16'hFFF0); idle(2);
    cur_req = "R4"; cyc(1, 8'(STB), 8'hA5); idle(20);
    cur_req = "R8"; put_pof(0, 16'h8001); cyc(1, 8'(STB), 8'h00); idle(8);
    cur_req = "R5"; put_ftw(0, 32'hFFFF_0000); put_ftw(1, 32'hF000_0001);
    cyc(1, 8'(STB), 8'h3C); idle(40);
    cur_req = "R6"; cyc(1, 8'h00, 8'h01); idle(6); cyc(1, 8'h00, 8'h00); idle(5);
    cur_req = "R9"; cyc(1, 8'h10, 8'hFC); cyc(1, 8'h00, 8'h54); idle(3);
    cur_req = "R7"; cyc(1, 8'h10, 8'hFE); idle(3); cyc(1, 8'h10, 8'hA8); idle(4);
    cyc(1, 8'(STB), 8'h11); idle(6); cyc(1, 8'(STB), 8'h22); idle(6);
    cur_req = "R10";
    for (int o = 10; o < 16; o++) cyc(1, 8'(o), 8'hFF);
    for (int o = 1; o < 4; o++) cyc(1, 8'(16 + o), 8'hFF);
    cyc(1, 8'(STB + 1), 8'hFF); cyc(1, 8'hFF, 8'h5A); idle(4);
    cyc(1, 8'(STB), 8'h00); idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule